// File: doc/BRIEF.md
# Audio Transfer Control Registers

This block is the host-facing control logic that governs how sample data moves between an audio converter and system memory. The host reaches a transfer configuration register, an output-pin and interrupt register, and a sample-count register through one indexed register port. The configuration decides, separately for playback and for capture, whether samples move through DMA requests or through a programmed-I/O data register. It also selects a single-channel mode that carries both directions on the playback request line.

Most of the configuration can only change while the host holds the mode-change input high. The two direction-enable bits are the exception and always accept a write. When the mode-change input falls, or when the power-down input is released, the block pulses a calibration-start strobe, provided automatic calibration is selected. A down-counter reloaded from the programmed count raises an interrupt once that many samples have moved. Sample-ready events from the converter side arrive as one-cycle strobes.

Top module: `xfer_ctl`

## Requirements
- R1: After reset, index 9 (configuration) reads 0x08, index 10 (pin control) reads 0x00, and play_req, cap_req, cal_start, irq and ext_pin are all 0.
- R2: A write to index 9 while mode_chg is 0 updates only bit 0 (playback enable) and bit 1 (capture enable). Bits 7, 6, 3 and 2 keep their value.
- R3: A write to index 9 while mode_chg is 1 updates bit 7 (capture PIO), bit 6 (playback PIO), bit 3 (auto-calibrate) and bit 2 (single channel) as well. Reserved bits 5:4 always read 0, and any unmapped index reads 0.
- R4: With playback enabled and bit 6 clear, play_req rises one cycle after a play_smp_rdy strobe and falls one cycle after play_ack. A strobe in the same cycle as the acknowledge keeps the request high. Capture behaves the same way on cap_smp_rdy, cap_ack and cap_req with bits 1 and 7.
- R5: With a direction's PIO bit set, that direction raises no DMA request, and its PIO-active output (play_pio_act or cap_pio_act) equals its enable bit.
- R6: With a direction's enable bit at 0, its strobes raise no request and its PIO-active output is 0.
- R7: With bit 2 set, cap_req stays 0. Capture requests appear on play_req and are cleared by play_ack, while cap_ack has no effect. If playback is also enabled, capture strobes raise nothing.
- R8: With bit 3 set, cal_start pulses high for one cycle, in the cycle after mode_chg is sampled falling or pwr_dn is sampled falling. With bit 3 clear, no pulse occurs.
- R9: In index 10, bits 7:6 drive ext_pin[1:0] directly and bit 1 is the interrupt enable. Bits 5:2 and bit 0 ignore written data and read 0.
- R10: The sample count is written at index 14 (low byte) and index 15 (high byte). A transfer is a DMA acknowledge of a pending request, or a strobe in PIO mode. The count applies to playback while it is enabled, and otherwise to capture. With interrupt enable set, irq goes high in the cycle after the transfer that completes the programmed count. The counter then reloads. With interrupt enable clear, irq does not rise.
- R11: irq stays high until an irq_clr pulse, and it is low in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 8 | Write data |
| rd_idx | input | 4 | Read index |
| rd_data | output | 8 | Read data (combinational on rd_idx) |
| mode_chg | input | 1 | Mode-change enable level |
| pwr_dn | input | 1 | Power-down level |
| play_smp_rdy | input | 1 | Playback sample-ready strobe |
| cap_smp_rdy | input | 1 | Capture sample-ready strobe |
| play_ack | input | 1 | Acknowledge for play_req |
| cap_ack | input | 1 | Acknowledge for cap_req |
| irq_clr | input | 1 | Interrupt clear strobe |
| play_req | output | 1 | Playback (or shared) DMA request |
| cap_req | output | 1 | Capture DMA request |
| play_pio_act | output | 1 | Playback PIO data register active |
| cap_pio_act | output | 1 | Capture PIO data register active |
| cal_start | output | 1 | Calibration start pulse |
| ext_pin | output | 2 | General-purpose output pins |
| irq | output | 1 | Sample-count interrupt |

## Verification
The request properties assume that acknowledges and sample strobes are single-cycle events, and that the host holds mode_chg as a level around its writes rather than toggling it inside a write cycle. The stimulus drives every input on the falling clock edge and releases each strobe one cycle later. The bench raises acknowledges only after the matching request is visible, and it changes the configuration only between completed handshakes. The calibration property also takes pwr_dn to be a slow level, which the stimulus keeps high for several cycles before releasing it.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int DAT_W = 8;
  localparam int NCH   = 2;
  localparam int CH_PLAY = 0;
  localparam int CH_CAP  = 1;

  typedef struct packed {
    logic       cap_pio;
    logic       play_pio;
    logic [1:0] rsv;
    logic       acal;
    logic       one_ch;
    logic       cap_en;
    logic       play_en;
  } xfc_cfg_t;

  localparam xfc_cfg_t CFG_RST = xfc_cfg_t'(8'h08);
endpackage

// File: rtl/xfc_regfile.sv
module xfc_regfile
  import xfc_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 16,
  parameter int IDX_CFG  = 9,
  parameter int IDX_PIN  = 10,
  parameter int IDX_BASE = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DAT_W-1:0]   wr_data,
  input  logic               mode_chg,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DAT_W-1:0]   rd_data,
  output xfc_cfg_t           cfg_q,
  output logic [1:0]         ext_q,
  output logic               ien_q,
  output logic [CNT_W-1:0]   base_q,
  output logic               base_load
);
  localparam int BASE_BYTES = (CNT_W + DAT_W - 1) / DAT_W;

  logic [BASE_BYTES*DAT_W-1:0] base_pad;
  logic cfg_hit, pin_hit, base_hit;

  assign cfg_hit = wr_en && (wr_idx == IDX_W'(IDX_CFG));
  assign pin_hit = wr_en && (wr_idx == IDX_W'(IDX_PIN));

  always_comb begin
    base_hit = 1'b0;
    for (int b = 0; b < BASE_BYTES; b++)
      if (wr_en && (wr_idx == IDX_W'(IDX_BASE + b))) base_hit = 1'b1;
  end

  // Enables are always writable; the rest only under mode change.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (cfg_hit) begin
      cfg_q.play_en <= wr_data[0];
      cfg_q.cap_en  <= wr_data[1];
      if (mode_chg) begin
        cfg_q.one_ch   <= wr_data[2];
        cfg_q.acal     <= wr_data[3];
        cfg_q.play_pio <= wr_data[6];
        cfg_q.cap_pio  <= wr_data[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      ien_q <= 1'b0;
    end else if (pin_hit) begin
      ext_q <= wr_data[7:6];
      ien_q <= wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pad  <= '0;
      base_load <= 1'b0;
    end else begin
      base_load <= base_hit;
      for (int b = 0; b < BASE_BYTES; b++)
        if (wr_en && (wr_idx == IDX_W'(IDX_BASE + b)))
          base_pad[b*DAT_W +: DAT_W] <= wr_data;
    end
  end

  assign base_q = base_pad[CNT_W-1:0];

  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_W'(IDX_CFG)) rd_data = cfg_q;
    if (rd_idx == IDX_W'(IDX_PIN)) rd_data = {ext_q, 4'b0000, ien_q, 1'b0};
    for (int b = 0; b < BASE_BYTES; b++)
      if (rd_idx == IDX_W'(IDX_BASE + b)) rd_data = base_pad[b*DAT_W +: DAT_W];
  end
endmodule

// File: rtl/xfc_req_chan.sv
module xfc_req_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic smp_rdy,
  input  logic ack,
  output logic req,
  output logic xfer
);
  logic pend;

  // A fresh strobe wins over an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (!en)     pend <= 1'b0;
    else if (smp_rdy) pend <= 1'b1;
    else if (ack)     pend <= 1'b0;
  end

  assign req  = pend & en;
  assign xfer = pend & en & ack;
endmodule

// File: rtl/xfc_cal_trig.sv
module xfc_cal_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic acal,
  input  logic mode_chg,
  input  logic pwr_dn,
  output logic cal_start
);
  logic mode_q, pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      pwr_q     <= 1'b0;
      cal_start <= 1'b0;
    end else begin
      mode_q    <= mode_chg;
      pwr_q     <= pwr_dn;
      cal_start <= acal & ((mode_q & ~mode_chg) | (pwr_q & ~pwr_dn));
    end
  end
endmodule

// File: rtl/xfc_smp_cnt.sv
module xfc_smp_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] base,
  input  logic             load,
  input  logic             evt,
  input  logic             ien,
  input  logic             clr,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  // Count of zero behaves as one: every transfer completes it.
  assign last = (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= base;
    else if (evt)      cnt <= last ? base : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq <= 1'b0;
    else if (evt && last && !load && ien) irq <= 1'b1;
    else if (clr)                        irq <= 1'b0;
  end
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import xfc_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 16,
  parameter int IDX_CFG  = 9,
  parameter int IDX_PIN  = 10,
  parameter int IDX_BASE = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             mode_chg,
  input  logic             pwr_dn,
  input  logic             play_smp_rdy,
  input  logic             cap_smp_rdy,
  input  logic             play_ack,
  input  logic             cap_ack,
  input  logic             irq_clr,
  output logic             play_req,
  output logic             cap_req,
  output logic             play_pio_act,
  output logic             cap_pio_act,
  output logic             cal_start,
  output logic [1:0]       ext_pin,
  output logic             irq
);
  xfc_cfg_t         cfg_q;
  logic [1:0]       ext_q;
  logic             ien_q;
  logic [CNT_W-1:0] base_q;
  logic             base_load;

  xfc_regfile #(
    .IDX_W(IDX_W), .CNT_W(CNT_W),
    .IDX_CFG(IDX_CFG), .IDX_PIN(IDX_PIN), .IDX_BASE(IDX_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .mode_chg(mode_chg), .rd_idx(rd_idx),
    .rd_data(rd_data), .cfg_q(cfg_q), .ext_q(ext_q), .ien_q(ien_q),
    .base_q(base_q), .base_load(base_load)
  );

  logic [NCH-1:0] ch_en, ch_rdy, ch_ack, ch_req, ch_xfer;

  // Single-channel mode: capture is shut out while playback is enabled
  // and its handshake moves onto the playback acknowledge.
  assign ch_en[CH_PLAY]  = cfg_q.play_en & ~cfg_q.play_pio;
  assign ch_en[CH_CAP]   = cfg_q.cap_en & ~cfg_q.cap_pio
                         & ~(cfg_q.one_ch & cfg_q.play_en);
  assign ch_rdy[CH_PLAY] = play_smp_rdy;
  assign ch_rdy[CH_CAP]  = cap_smp_rdy;
  assign ch_ack[CH_PLAY] = play_ack;
  assign ch_ack[CH_CAP]  = cfg_q.one_ch ? play_ack : cap_ack;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    xfc_req_chan u_chan (
      .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .smp_rdy(ch_rdy[c]),
      .ack(ch_ack[c]), .req(ch_req[c]), .xfer(ch_xfer[c])
    );
  end

  assign play_req     = ch_req[CH_PLAY] | (cfg_q.one_ch & ch_req[CH_CAP]);
  assign cap_req      = ~cfg_q.one_ch & ch_req[CH_CAP];
  assign play_pio_act = cfg_q.play_en & cfg_q.play_pio;
  assign cap_pio_act  = cfg_q.cap_en & cfg_q.cap_pio;
  assign ext_pin      = ext_q;

  logic play_evt, cap_evt, cnt_evt;
  assign play_evt = ch_xfer[CH_PLAY] | (play_pio_act & play_smp_rdy);
  assign cap_evt  = ch_xfer[CH_CAP] | (cap_pio_act & cap_smp_rdy);
  assign cnt_evt  = cfg_q.play_en ? play_evt : cap_evt;

  xfc_smp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .base(base_q), .load(base_load),
    .evt(cnt_evt), .ien(ien_q), .clr(irq_clr), .irq(irq)
  );

  xfc_cal_trig u_cal (
    .clk(clk), .rst_n(rst_n), .acal(cfg_q.acal), .mode_chg(mode_chg),
    .pwr_dn(pwr_dn), .cal_start(cal_start)
  );
endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       mode_chg,
  input logic [7:0] cfg_bits,
  input logic       ien,
  input logic       play_req,
  input logic       cap_req,
  input logic       play_ack,
  input logic       play_smp_rdy,
  input logic       cap_smp_rdy,
  input logic       cal_start,
  input logic       irq
);
  AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |=> $stable(cfg_bits[7:2])); // R2

  AST_PLAY_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    play_req |-> ((cfg_bits[0] && !cfg_bits[6]) ||
                  (cfg_bits[2] && cfg_bits[1] && !cfg_bits[7]))); // R5

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (play_req && play_ack && !play_smp_rdy && !cap_smp_rdy && !wr_en)
      |=> !play_req); // R4

  AST_ONE_CH_CAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[2] |-> !cap_req); // R7

  AST_CAL_NEEDS_ACAL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(cfg_bits[3])); // R8

  AST_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien)); // R10
endmodule

bind xfer_ctl xfer_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_chg(mode_chg),
  .cfg_bits(cfg_q), .ien(ien_q), .play_req(play_req), .cap_req(cap_req),
  .play_ack(play_ack), .play_smp_rdy(play_smp_rdy),
  .cap_smp_rdy(cap_smp_rdy), .cal_start(cal_start), .irq(irq)
);

// File: tb/xfer_ctl_test.sv
module xfer_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       mode_chg = 1'b0, pwr_dn = 1'b0;
  logic       play_smp_rdy = 1'b0, cap_smp_rdy = 1'b0;
  logic       play_ack = 1'b0, cap_ack = 1'b0, irq_clr = 1'b0;
  logic       play_req, cap_req, play_pio_act, cap_pio_act, cal_start, irq;
  logic [1:0] ext_pin;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  xfer_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .mode_chg(mode_chg), .pwr_dn(pwr_dn), .play_smp_rdy(play_smp_rdy),
    .cap_smp_rdy(cap_smp_rdy), .play_ack(play_ack), .cap_ack(cap_ack),
    .irq_clr(irq_clr), .play_req(play_req), .cap_req(cap_req),
    .play_pio_act(play_pio_act), .cap_pio_act(cap_pio_act),
    .cal_start(cal_start), .ext_pin(ext_pin), .irq(irq)
  );

  // {mode_chg, index, write data, expected read-back}
  localparam logic [20:0] VECS [0:8] = '{
    {1'b1, 4'd9,  8'hFF, 8'hCF},  // R3 all writable, reserved read 0
    {1'b0, 4'd9,  8'h00, 8'hCC},  // R2 only enables clear
    {1'b0, 4'd9,  8'h03, 8'hCF},  // R2 enables set
    {1'b1, 4'd9,  8'h00, 8'h00},  // R3 clear all
    {1'b0, 4'd9,  8'hFC, 8'h00},  // R2 protected bits held
    {1'b1, 4'd10, 8'hFF, 8'hC2},  // R9 reserved pin bits read 0
    {1'b0, 4'd10, 8'h40, 8'h40},  // R9 no mode-change needed
    {1'b0, 4'd14, 8'hA5, 8'hA5},  // R10 count low byte
    {1'b0, 4'd3,  8'hFF, 8'h00}   // R3 unmapped index
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] d);
    rd_idx = i;
    #1;
    d = rd_data;
  endtask

  task automatic play_strobe();
    @(negedge clk); play_smp_rdy = 1'b1;
    @(negedge clk); play_smp_rdy = 1'b0;
  endtask

  task automatic cap_strobe();
    @(negedge clk); cap_smp_rdy = 1'b1;
    @(negedge clk); cap_smp_rdy = 1'b0;
  endtask

  task automatic play_ack_pulse();
    @(negedge clk); play_ack = 1'b1;
    @(negedge clk); play_ack = 1'b0;
  endtask

  task automatic cap_ack_pulse();
    @(negedge clk); cap_ack = 1'b1;
    @(negedge clk); cap_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_chg = 1'b0; pwr_dn = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    do_reset();
    tick();
    rd(4'd9, d);  chk("R1 cfg reset", d, 8'h08);
    rd(4'd10, d); chk("R1 pin reset", d, 8'h00);
    chk("R1 outputs reset", {play_req, cap_req, cal_start, irq, ext_pin}, 0);

    for (int k = 0; k < 9; k++) begin
      mode_chg = VECS[k][20];
      wr(VECS[k][19:16], VECS[k][15:8]);
      rd(VECS[k][19:16], d);
      chk($sformatf("R2/R3/R9 vector %0d", k), d, VECS[k][7:0]);
    end
    mode_chg = 1'b0;

    do_reset();
    // R4 playback handshake
    wr(4'd9, 8'h01);
    chk("R4 idle", play_req, 0);
    play_strobe();
    chk("R4 play_req rise", play_req, 1);
    chk("R4 cap quiet", cap_req, 0);
    play_ack_pulse();
    chk("R4 play_req fall", play_req, 0);
    play_strobe();
    @(negedge clk); play_ack = 1'b1; play_smp_rdy = 1'b1;
    @(negedge clk); play_ack = 1'b0; play_smp_rdy = 1'b0;
    chk("R4 strobe beats ack", play_req, 1);
    play_ack_pulse();
    // R4 capture handshake
    wr(4'd9, 8'h02);
    cap_strobe();
    chk("R4 cap_req rise", {cap_req, play_req}, 2'b10);
    cap_ack_pulse();
    chk("R4 cap_req fall", cap_req, 0);
    // R6 disabled
    wr(4'd9, 8'h00);
    play_strobe(); cap_strobe();
    chk("R6 no requests", {play_req, cap_req, play_pio_act, cap_pio_act}, 0);
    // R5 PIO, plus R8 calibration on mode-change release
    mode_chg = 1'b1;
    wr(4'd9, 8'hCB);
    mode_chg = 1'b0;
    tick();
    chk("R8 cal pulse on mode release", cal_start, 1);
    tick();
    chk("R8 cal one cycle", cal_start, 0);
    play_strobe(); cap_strobe();
    chk("R5 no DMA in PIO", {play_req, cap_req}, 0);
    chk("R5 PIO active", {play_pio_act, cap_pio_act}, 2'b11);
    // R7 single channel, calibration off
    mode_chg = 1'b1;
    wr(4'd9, 8'h06);
    mode_chg = 1'b0;
    tick();
    chk("R8 no pulse with acal clear", cal_start, 0);
    cap_strobe();
    chk("R7 capture on play line", {play_req, cap_req}, 2'b10);
    cap_ack_pulse();
    chk("R7 cap_ack ignored", play_req, 1);
    play_ack_pulse();
    chk("R7 play_ack clears", play_req, 0);
    wr(4'd9, 8'h07);
    cap_strobe();
    chk("R7 playback priority", play_req, 0);
    play_strobe();
    chk("R7 playback served", play_req, 1);
    play_ack_pulse();
    // R8 power-down release
    mode_chg = 1'b1;
    wr(4'd9, 8'h08);
    mode_chg = 1'b0;
    tick(); tick();
    pwr_dn = 1'b1;
    tick(); tick();
    chk("R8 no pulse while powered down", cal_start, 0);
    pwr_dn = 1'b0;
    tick();
    chk("R8 cal pulse on power-up", cal_start, 1);
    // R9 pins
    wr(4'd10, 8'h80);
    chk("R9 ext pins", ext_pin, 2'b10);
    wr(4'd10, 8'h3D);
    rd(4'd10, d);
    chk("R9 reserved ignored", {d, ext_pin}, 10'h000);
    // R10 count-based interrupt
    wr(4'd14, 8'h03); wr(4'd15, 8'h00);
    wr(4'd10, 8'h02);
    wr(4'd9, 8'h09);
    for (int t = 0; t < 2; t++) begin play_strobe(); play_ack_pulse(); end
    chk("R10 irq low before count", irq, 0);
    play_strobe(); play_ack_pulse();
    chk("R10 irq at count", irq, 1);
    // R11 sticky and clear
    tick(); tick();
    chk("R11 irq held", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R11 irq cleared", irq, 0);
    // R10 enable off: count completes silently
    wr(4'd10, 8'h00);
    for (int t = 0; t < 3; t++) begin play_strobe(); play_ack_pulse(); end
    chk("R10 irq masked", irq, 0);

    finish_run();
  end
endmodule